// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single receive line. Its timing comes from an enable pulse, `rx_clk_en`, that runs at 1, 16 or 64 times the bit rate. The ratio is picked at run time. For example, a 1.8432 MHz enable at the 16x setting gives 115200 bit/s. The word format is also picked at run time: 7 or 8 data bits, with or without a parity bit, and one stop bit. The common setting is 8 data bits, no parity and one stop bit.

Each finished character goes into a holding register and raises a ready flag. The flag stays up until the host pulses `data_rd`. Parity and framing results travel with the character. If a new character finishes while the old one is still unread, the old one is kept, the new one is dropped and an overrun flag is raised. A master-reset input clears every flag and abandons any frame in progress. An interrupt request is raised whenever there is something to service.

Top module: `arx_receiver`

## Requirements
- R1: Only cycles with `rx_clk_en` high advance the receiver. With `div_sel` = 01 (16x) or 10/11 (64x), a low level on `rxd` while idle is taken as a start candidate. The candidate is re-checked 8 (16x) or 32 (64x) enable ticks later. Each following bit is then sampled every 16 or 64 ticks, so characters are recovered correctly at both ratios.
- R2: With `div_sel` = 00 (1x), every enable tick is one bit. The tick that sees `rxd` low while idle is the start bit, and each following tick samples the next bit. There is no confirmation step.
- R3: Data bits arrive least significant first. `fmt_sel[2]` = 1 selects 8 data bits and 0 selects 7 data bits. In 7-bit mode, `rx_data[7]` reads 0.
- R4: `fmt_sel[1]` = 1 adds a parity bit after the data bits. `fmt_sel[0]` = 1 selects odd parity and 0 selects even parity. `pe` is 1 when the received parity bit does not match. `pe` is 0 when parity is disabled.
- R5: `fe` is set when the stop bit samples low. It stays with its character until that character is read.
- R6: A finished character is placed on `rx_data` and sets `rdrf`. A `data_rd` pulse clears `rdrf`, `fe`, `pe` and `ovrn`.
- R7: If a character finishes while `rdrf` is set and no read is taken in that cycle, `ovrn` is set. `rx_data` keeps the older character and the new one is discarded.
- R8: If a read and a character completion fall in the same cycle, the new character is loaded, `rdrf` stays set and `ovrn` stays clear.
- R9: At 16x or 64x, a low pulse on `rxd` that has gone high again at the confirmation point is ignored. No character is produced.
- R10: A one-cycle `mreset` clears `rdrf`, `ovrn`, `fe` and `pe`, and aborts any frame in progress. The receiver then waits for a new start bit.
- R11: `irq` is high exactly while `rdrf` or `ovrn` is set.
- R12: After `rst`, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_en | input | 1 | Sampling enable at 1x/16x/64x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| div_sel | input | 2 | 00 = 1x, 01 = 16x, 10 or 11 = 64x |
| fmt_sel | input | 3 | [2] 8-bit word, [1] parity on, [0] odd parity |
| data_rd | input | 1 | Read strobe for the holding register |
| mreset | input | 1 | Master reset of receiver and flags |
| rx_data | output | 8 | Held character |
| rdrf | output | 1 | Character ready |
| ovrn | output | 1 | Overrun |
| fe | output | 1 | Framing error of the held character |
| pe | output | 1 | Parity error of the held character |
| irq | output | 1 | Receive service request |

## Verification
A host read and a character completion can land on the same clock edge. This is the one place where the holding-register update has to choose between two events. The case is provoked in 1x mode, where the stop bit is sampled on a known tick, by raising `data_rd` for exactly that edge. The result is judged at the ports: `rx_data` must show the new character, `rdrf` must still be set and `ovrn` must be clear. A separate case completes a character with no read pending, and there the older byte must survive and `ovrn` must rise.

// File: rtl/arx_pkg.sv
package arx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic word8;
        logic par_en;
        logic par_odd;
    } rx_fmt_t;

    typedef struct packed {
        logic [7:0] data;
        logic       fe;
        logic       pe;
    } rx_char_t;

    localparam logic [1:0] DIV_X1 = 2'b00;
    localparam logic [1:0] DIV_X16 = 2'b01;

    // parity mismatch: data plus parity bit must have an odd count of ones when odd is set
    function automatic logic par_mismatch(logic [7:0] d, logic pbit, logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/arx_baud.sv
module arx_baud
    import arx_pkg::*;
#(
    parameter int RATIO_MID  = 16,
    parameter int RATIO_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  logic       half,
    input  logic [1:0] div_sel,
    output logic       sample
);
    localparam int CW = $clog2(RATIO_HIGH);

    logic [CW-1:0] cnt;
    logic [CW-1:0] full_m1;
    logic [CW-1:0] half_m1;
    logic [CW-1:0] lim_m1;

    always_comb begin
        case (div_sel)
            DIV_X1: begin
                full_m1 = '0;
                half_m1 = '0;
            end
            DIV_X16: begin
                full_m1 = CW'(RATIO_MID - 1);
                half_m1 = CW'(RATIO_MID / 2 - 1);
            end
            default: begin
                full_m1 = CW'(RATIO_HIGH - 1);
                half_m1 = CW'(RATIO_HIGH / 2 - 1);
            end
        endcase
        lim_m1 = half ? half_m1 : full_m1;
        sample = tick && (cnt == lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == lim_m1) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/arx_frame.sv
module arx_frame
    import arx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     x1_mode,
    input  rx_fmt_t  fmt,
    input  logic     sample,
    output logic     restart,
    output logic     half,
    output logic     done,
    output rx_char_t ch
);
    rx_state_e  state;
    logic [7:0] shreg;
    logic [2:0] bidx;
    logic       par_bit;
    logic       last_bit;

    assign restart  = (state == ST_IDLE);
    assign half     = (state == ST_START);
    assign last_bit = (bidx == (fmt.word8 ? 3'd7 : 3'd6));

    always_comb begin
        done    = (state == ST_STOP) && sample;
        ch.data = shreg;
        ch.fe   = !rxd;
        ch.pe   = fmt.par_en && par_mismatch(shreg, par_bit, fmt.par_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bidx    <= '0;
            par_bit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tick && !rxd) begin
                        shreg <= '0;
                        bidx  <= '0;
                        state <= x1_mode ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (sample) state <= rxd ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (sample) begin
                        shreg[bidx] <= rxd;
                        bidx        <= bidx + 3'd1;
                        if (last_bit) state <= fmt.par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (sample) begin
                        par_bit <= rxd;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (sample) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a completion is a single-cycle event
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/arx_hold.sv
module arx_hold
    import arx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  rx_char_t ch,
    input  logic     data_rd,
    output rx_char_t hold,
    output logic     rdrf,
    output logic     ovrn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            rdrf <= 1'b0;
            ovrn <= 1'b0;
        end else if (done && (!rdrf || data_rd)) begin
            hold <= ch;
            rdrf <= 1'b1;
            ovrn <= 1'b0;
        end else if (done) begin
            ovrn <= 1'b1;
        end else if (data_rd) begin
            rdrf    <= 1'b0;
            ovrn    <= 1'b0;
            hold.fe <= 1'b0;
            hold.pe <= 1'b0;
        end
    end

    p_ovrn_needs_rdrf_r7: assert property (@(posedge clk) disable iff (rst)
        ovrn |-> rdrf);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !done) |=> (!rdrf && !ovrn));

    p_keep_old_r7: assert property (@(posedge clk) disable iff (rst)
        (rdrf && done && !data_rd) |=> (hold.data == $past(hold.data) && ovrn));

    p_collide_r8: assert property (@(posedge clk) disable iff (rst)
        (rdrf && done && data_rd) |=> (rdrf && !ovrn));

endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
    import arx_pkg::*;
#(
    parameter int RATIO_MID  = 16,
    parameter int RATIO_HIGH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_clk_en,
    input  logic       rxd,
    input  logic [1:0] div_sel,
    input  logic [2:0] fmt_sel,
    input  logic       data_rd,
    input  logic       mreset,
    output logic [7:0] rx_data,
    output logic       rdrf,
    output logic       ovrn,
    output logic       fe,
    output logic       pe,
    output logic       irq
);
    logic     rst_i;
    logic     x1_mode;
    rx_fmt_t  fmt;
    logic     sample;
    logic     restart;
    logic     half;
    logic     done;
    rx_char_t ch;
    rx_char_t hold;

    assign rst_i   = rst || mreset;
    assign x1_mode = (div_sel == DIV_X1);
    assign fmt     = rx_fmt_t'(fmt_sel);

    arx_baud #(
        .RATIO_MID (RATIO_MID),
        .RATIO_HIGH(RATIO_HIGH)
    ) baud_i (
        .clk    (clk),
        .rst    (rst_i),
        .tick   (rx_clk_en),
        .restart(restart),
        .half   (half),
        .div_sel(div_sel),
        .sample (sample)
    );

    arx_frame frame_i (
        .clk    (clk),
        .rst    (rst_i),
        .tick   (rx_clk_en),
        .rxd    (rxd),
        .x1_mode(x1_mode),
        .fmt    (fmt),
        .sample (sample),
        .restart(restart),
        .half   (half),
        .done   (done),
        .ch     (ch)
    );

    arx_hold hold_i (
        .clk    (clk),
        .rst    (rst_i),
        .done   (done),
        .ch     (ch),
        .data_rd(data_rd),
        .hold   (hold),
        .rdrf   (rdrf),
        .ovrn   (ovrn)
    );

    assign rx_data = hold.data;
    assign fe      = hold.fe;
    assign pe      = hold.pe;
    assign irq     = rdrf || ovrn;

    p_mreset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (!rdrf && !ovrn && !fe && !pe));

endmodule

// File: tb/arx_receiver_tb_top.sv
module arx_receiver_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] div_sel = 2'b01;
    logic [2:0] fmt_sel = 3'b100;
    logic       data_rd = 1'b0;
    logic       mreset = 1'b0;
    logic [7:0] rx_data;
    logic       rdrf, ovrn, fe, pe, irq;
    logic [31:0] cyc = '0;
    logic       en;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    assign en = cyc[0];

    always #5 clk = ~clk;

    initial forever @(posedge clk) cyc <= cyc + 1;

    arx_receiver dut_i (
        .clk      (clk),
        .rst      (rst),
        .rx_clk_en(en),
        .rxd      (rxd),
        .div_sel  (div_sel),
        .fmt_sel  (fmt_sel),
        .data_rd  (data_rd),
        .mreset   (mreset),
        .rx_data  (rx_data),
        .rdrf     (rdrf),
        .ovrn     (ovrn),
        .fe       (fe),
        .pe       (pe),
        .irq      (irq)
    );

    // vector: [15:14] div, [13:11] fmt, [10] bad parity, [9] bad stop, [7:0] data
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {2'b01, 3'b100, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b10, 3'b100, 1'b0, 1'b0, 1'b0, 8'h3C},
        {2'b00, 3'b100, 1'b0, 1'b0, 1'b0, 8'hC3},
        {2'b01, 3'b000, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b01, 3'b110, 1'b0, 1'b0, 1'b0, 8'h96},
        {2'b00, 3'b111, 1'b1, 1'b0, 1'b0, 8'h81},
        {2'b10, 3'b011, 1'b0, 1'b0, 1'b0, 8'h55},
        {2'b01, 3'b100, 1'b0, 1'b1, 1'b0, 8'h5A},
        {2'b11, 3'b110, 1'b1, 1'b0, 1'b0, 8'h0F}
    };

    function automatic int ratio_of(logic [1:0] d);
        return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic align();
        @(negedge clk);
        while (!en) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, bit badpar, bit badstop, bit collide);
        int   r = ratio_of(div_sel);
        int   nb = fmt_sel[2] ? 8 : 7;
        logic [7:0] dm = fmt_sel[2] ? d : {1'b0, d[6:0]};
        logic p = (^dm) ^ fmt_sel[0] ^ badpar;
        align();
        rxd = 1'b0;
        repeat (2 * r) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = dm[i];
            repeat (2 * r) @(negedge clk);
        end
        if (fmt_sel[1]) begin
            rxd = p;
            repeat (2 * r) @(negedge clk);
        end
        rxd = !badstop;
        if (collide) data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        repeat (2 * r - 1) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * r) @(negedge clk);
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "rdrf", rdrf, 0);
        chk("R12", "ovrn", ovrn, 0);
        chk("R12", "fe/pe", {fe, pe}, 0);
        chk("R12", "irq", irq, 0);
        chk("R12", "rx_data", rx_data, 0);

        // table walk: R1 (16x/64x), R2 (1x), R3 (7-bit), R4 parity, R5 stop, R6 ready
        for (int v = 0; v < NV; v++) begin
            logic [7:0] exp_d;
            string      rq;
            div_sel = VEC[v][15:14];
            fmt_sel = VEC[v][13:11];
            send(VEC[v][7:0], VEC[v][10], VEC[v][9], 1'b0);
            exp_d = fmt_sel[2] ? VEC[v][7:0] : {1'b0, VEC[v][6:0]};
            rq = (div_sel == 2'b00) ? "R2" : (fmt_sel[2] ? "R1" : "R3");
            chk(rq, "rx_data", rx_data, exp_d);
            chk("R6", "rdrf", rdrf, 1);
            chk("R11", "irq", irq, 1);
            chk("R4", "pe", pe, VEC[v][10] & fmt_sel[1]);
            chk("R5", "fe", fe, VEC[v][9]);
            chk("R7", "ovrn", ovrn, 0);
            rd_pulse();
            chk("R6", "rdrf after read", rdrf, 0);
            chk("R5", "fe after read", fe, 0);
        end

        // R7 overrun: older byte kept
        div_sel = 2'b01;
        fmt_sel = 3'b100;
        send(8'h11, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        chk("R7", "ovrn set", ovrn, 1);
        chk("R7", "old byte kept", rx_data, 8'h11);
        chk("R11", "irq on overrun", irq, 1);
        rd_pulse();
        chk("R7", "ovrn cleared", ovrn, 0);
        chk("R6", "rdrf cleared", rdrf, 0);
        chk("R11", "irq idle", irq, 0);

        // R8 read coincident with completion
        div_sel = 2'b00;
        send(8'h33, 0, 0, 0);
        chk("R2", "first byte", rx_data, 8'h33);
        send(8'h44, 0, 0, 1);
        chk("R8", "new byte", rx_data, 8'h44);
        chk("R8", "rdrf held", rdrf, 1);
        chk("R8", "no overrun", ovrn, 0);
        rd_pulse();

        // R9 false start at 16x
        div_sel = 2'b01;
        align();
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        chk("R9", "no char from glitch", rdrf, 0);
        send(8'h6E, 0, 0, 0);
        chk("R9", "char after glitch", rx_data, 8'h6E);
        chk("R9", "ready after glitch", rdrf, 1);
        rd_pulse();

        // R10 master reset mid-frame with flags set
        send(8'h77, 0, 0, 0);
        send(8'h88, 0, 0, 0);
        chk("R10", "precondition ovrn", ovrn, 1);
        align();
        rxd = 1'b0;
        repeat (2 * 16 * 3) @(negedge clk);
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
        rxd = 1'b1;
        chk("R10", "flags cleared", {rdrf, ovrn, fe, pe}, 0);
        repeat (600) @(negedge clk);
        chk("R10", "no char after abort", rdrf, 0);
        send(8'h99, 0, 0, 0);
        chk("R10", "resync byte", rx_data, 8'h99);
        rd_pulse();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule